// File: doc/BRIEF.md
# Single-Cycle Integer Core

A small processor core that completes one instruction per clock. Every instruction is a single 32-bit word fetched from an internal word-addressed instruction store. The core decodes it, reads two operands from a 32 x 32-bit register file, computes a result, writes the result back and selects the next program counter, all within the same cycle. The instruction subset covers these operations:

- register-register add, subtract and signed set-less-than
- add-immediate and signed set-less-than-immediate
- OR with a zero-extended immediate
- load of a constant into the upper half of a register
- branch on equal and branch on not-equal
- an absolute jump within the current 256 MB region

The instruction store is loaded through a simple write port while the core is held in reset. Reset clears the program counter and the registers but leaves the instruction store as it is. A registered debug port reads any register by number, so software state can be observed without stopping the core.

Top module: `tiny_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears every register to zero. The instruction store keeps its contents through reset.
- R2: Instruction bits are [31:26] opcode, [25:21] source A, [20:16] source B/target, [15:11] destination, and [5:0] function code. Opcode 0 with function code 32 writes A+B to the destination. Opcode 0 with function code 34 writes A-B to the destination.
- R3: Opcode 0 with function code 42 writes 1 to the destination when A is less than B as signed values, and writes 0 otherwise.
- R4: Opcode 8 writes A plus the sign-extended 16-bit immediate (bits [15:0]) to the target. Opcode 10 writes 1 to the target when A is less than the sign-extended immediate as signed values, and writes 0 otherwise.
- R5: Opcode 13 writes A OR the zero-extended immediate to the target.
- R6: Opcode 15 writes the immediate into bits [31:16] of the target and clears bits [15:0].
- R7: Opcode 4 compares A with B. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R8: Opcode 5 takes the same branch when A and B differ. An offset of -4 placed in the fourth instruction of a loop returns control to the first instruction of the loop.
- R9: Opcode 2 sets the next PC to bits [31:28] of PC+4, followed by instruction bits [25:0], followed by two zero bits.
- R10: Register 0 always reads as zero, and writes that name it are discarded.
- R11: Any other opcode, and any function code under opcode 0 other than 32, 34 or 42, writes no register and advances the PC by 4.
- R12: Register N appears on the debug output one clock after N is presented at the debug address. The value shown is the register's state before that clock edge's write-back.
- R13: The PC output is the program counter register. Each rising edge outside reset replaces it with the next PC of the instruction it addressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IMEM_AW | Instruction store word address |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_raddr | input | 5 | Register number for the debug read |
| dbg_rdata | output | 32 | Registered debug read data |
| pc_out | output | 32 | Current program counter |

## Verification
Every instruction takes effect at the rising edge that follows its fetch. That one edge brings a new `pc_out` and makes the written register visible. A debug read shows up one edge after its address is applied, and it shows the register state from before that edge's write. The bench keeps a behavioural model that steps once per rising edge. It drives inputs and samples outputs on the falling edge, so the PC is compared on every cycle. For the debug value, the model's register contents are captured at the moment the address is applied and compared one cycle later. After the program halts on a jump to itself, literal register values chosen from the requirements are read back through the debug port.

// File: rtl/tiny_core_pkg.sv
package tiny_core_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_JMP  = 6'd2;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_SLTI = 6'd10;
  localparam logic [5:0] OP_ORI  = 6'd13;
  localparam logic [5:0] OP_LUI  = 6'd15;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_OR,
    ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SIGN,
    IMM_ZERO,
    IMM_UPPER
  } imm_kind_e;

  typedef struct packed {
    logic      reg_we;
    logic      dst_rd;
    logic      use_imm;
    imm_kind_e imm_kind;
    alu_op_e   alu_op;
    logic      br_eq;
    logic      br_ne;
    logic      jump;
    logic      illegal;
  } ctrl_t;

endpackage

// File: rtl/tiny_core_imem.sv
module tiny_core_imem #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/tiny_core_decode.sv
module tiny_core_decode
  import tiny_core_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);
  logic [5:0] opc;
  logic [5:0] fnc;

  assign opc = instr[31:26];
  assign fnc = instr[5:0];

  always_comb begin
    ctrl          = '0;
    ctrl.alu_op   = ALU_ADD;
    ctrl.imm_kind = IMM_SIGN;
    case (opc)
      OP_REG: begin
        ctrl.dst_rd = 1'b1;
        case (fnc)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
          default: ctrl.illegal = 1'b1;
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_ADD;
      end
      OP_SLTI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_SLT;
      end
      OP_ORI: begin
        ctrl.reg_we   = 1'b1;
        ctrl.use_imm  = 1'b1;
        ctrl.imm_kind = IMM_ZERO;
        ctrl.alu_op   = ALU_OR;
      end
      OP_LUI: begin
        ctrl.reg_we   = 1'b1;
        ctrl.use_imm  = 1'b1;
        ctrl.imm_kind = IMM_UPPER;
        ctrl.alu_op   = ALU_PASSB;
      end
      OP_BEQ: ctrl.br_eq = 1'b1;
      OP_BNE: ctrl.br_ne = 1'b1;
      OP_JMP: ctrl.jump  = 1'b1;
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/tiny_core_alu.sv
module tiny_core_alu
  import tiny_core_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] res
);
  always_comb begin
    case (op)
      ALU_ADD:   res = a + b;
      ALU_SUB:   res = a - b;
      ALU_SLT:   res = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_OR:    res = a | b;
      ALU_PASSB: res = b;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/tiny_core_regfile.sv
module tiny_core_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DW       = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_REGS)-1:0] ra_addr,
  output logic [DW-1:0]               ra_data,
  input  logic [$clog2(NUM_REGS)-1:0] rb_addr,
  output logic [DW-1:0]               rb_data,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
  input  logic [DW-1:0]               wr_data,
  input  logic [$clog2(NUM_REGS)-1:0] dbg_addr,
  output logic [DW-1:0]               dbg_data
);
  localparam int AW = $clog2(NUM_REGS);

  logic [DW-1:0] rf_q [NUM_REGS];
  logic [DW-1:0] dbg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) rf_q[i] <= '0;
    end else if (wr_en && (wr_addr != AW'(0))) begin
      rf_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_q <= '0;
    else     dbg_q <= rf_q[dbg_addr];
  end

  assign ra_data  = rf_q[ra_addr];
  assign rb_data  = rf_q[rb_addr];
  assign dbg_data = dbg_q;

  // R10: a write aimed at register 0 leaves it zero
  p_zero_reg_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(0)) |=> (rf_q[0] == '0));

  // R12: debug read of register 0 returns zero one cycle later
  p_dbg_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (dbg_addr == AW'(0)) |=> (dbg_data == '0));

endmodule

// File: rtl/tiny_core.sv
module tiny_core
  import tiny_core_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_waddr,
  input  logic [31:0]        imem_wdata,
  input  logic [4:0]         dbg_raddr,
  output logic [31:0]        dbg_rdata,
  output logic [31:0]        pc_out
);
  localparam int NUM_REGS = 1 << REG_AW;

  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_next;
  logic [XLEN-1:0]   pc_plus4;
  logic [XLEN-1:0]   br_off;
  logic [XLEN-1:0]   instr;
  ctrl_t             ctrl;
  logic [REG_AW-1:0] rs_f, rt_f, rd_f, wr_sel;
  logic [15:0]       imm16;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   a_val, b_val, alu_b, alu_res;
  logic              take_br;

  tiny_core_imem #(.AW(IMEM_AW), .DW(XLEN)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (imem_waddr),
    .wdata (imem_wdata),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (instr)
  );

  tiny_core_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  assign rs_f  = instr[25:21];
  assign rt_f  = instr[20:16];
  assign rd_f  = instr[15:11];
  assign imm16 = instr[15:0];

  always_comb begin
    case (ctrl.imm_kind)
      IMM_ZERO:  imm_ext = {16'h0000, imm16};
      IMM_UPPER: imm_ext = {imm16, 16'h0000};
      default:   imm_ext = {{16{imm16[15]}}, imm16};
    endcase
  end

  assign wr_sel = ctrl.dst_rd ? rd_f : rt_f;
  assign alu_b  = ctrl.use_imm ? imm_ext : b_val;

  tiny_core_regfile #(.NUM_REGS(NUM_REGS), .DW(XLEN)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .ra_addr  (rs_f),
    .ra_data  (a_val),
    .rb_addr  (rt_f),
    .rb_data  (b_val),
    .wr_en    (ctrl.reg_we),
    .wr_addr  (wr_sel),
    .wr_data  (alu_res),
    .dbg_addr (dbg_raddr),
    .dbg_data (dbg_rdata)
  );

  tiny_core_alu u_alu (
    .a   (a_val),
    .b   (alu_b),
    .op  (ctrl.alu_op),
    .res (alu_res)
  );

  assign pc_plus4 = pc_q + 32'd4;
  assign br_off   = {{14{imm16[15]}}, imm16, 2'b00};
  assign take_br  = (ctrl.br_eq && (a_val == b_val)) ||
                    (ctrl.br_ne && (a_val != b_val));

  always_comb begin
    if (ctrl.jump)   pc_next = {pc_plus4[31:28], instr[25:0], 2'b00};
    else if (take_br) pc_next = pc_plus4 + br_off;
    else             pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_out = pc_q;

  // R1: reset returns the PC to zero
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc_q == '0));

  // R13: straight-line instructions step the PC by one word
  p_pc_step_r13: assert property (@(posedge clk) disable iff (rst)
    (!take_br && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

  // R11: an unrecognised instruction only advances the PC
  p_nop_advance_r11: assert property (@(posedge clk) disable iff (rst)
    ctrl.illegal |=> (pc_q == $past(pc_q) + 32'd4));

  // R9: a jump keeps the top four bits of the incremented PC
  p_jump_region_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc_q[31:28] == $past(pc_plus4[31:28])));

  // R13: the PC stays word aligned
  p_pc_aligned_r13: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

endmodule

// File: tb/tiny_core_tb.sv
`timescale 1ns/1ps
module tiny_core_tb;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          imem_we = 1'b0;
  logic [AW-1:0] imem_waddr = '0;
  logic [31:0]   imem_wdata = '0;
  logic [4:0]    dbg_raddr = '0;
  logic [31:0]   dbg_rdata;
  logic [31:0]   pc_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] prog [DEPTH];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  logic [31:0] exp_dbg;
  logic [4:0]  sweep;

  always #5 clk = ~clk;

  tiny_core #(.IMEM_AW(AW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .imem_we    (imem_we),
    .imem_waddr (imem_waddr),
    .imem_wdata (imem_wdata),
    .dbg_raddr  (dbg_raddr),
    .dbg_rdata  (dbg_rdata),
    .pc_out     (pc_out)
  );

  function automatic logic [31:0] enc_r(int fn, int ra, int rb, int rd);
    return {6'd0, 5'(ra), 5'(rb), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int ra, int rt, int imm);
    return {6'(op), 5'(ra), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(int word_addr);
    return {6'd2, 26'(word_addr)};
  endfunction

  function automatic string tag_of(logic [31:0] ins);
    case (ins[31:26])
      6'd0: begin
        if (ins[5:0] == 6'd32 || ins[5:0] == 6'd34) return "R2";
        if (ins[5:0] == 6'd42) return "R3";
        return "R11";
      end
      6'd8, 6'd10: return "R4";
      6'd13: return "R5";
      6'd15: return "R6";
      6'd4:  return "R7";
      6'd5:  return "R8";
      6'd2:  return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mwrite(logic [4:0] idx, logic [31:0] val);
    if (idx != 5'd0) mreg[idx] = val;
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, sx, nxt;
    ins = prog[mpc[AW+1:2]];
    a   = mreg[ins[25:21]];
    b   = mreg[ins[20:16]];
    sx  = {{16{ins[15]}}, ins[15:0]};
    nxt = mpc + 4;
    case (ins[31:26])
      6'd0: case (ins[5:0])
        6'd32: mwrite(ins[15:11], a + b);
        6'd34: mwrite(ins[15:11], a - b);
        6'd42: mwrite(ins[15:11], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        default: ;
      endcase
      6'd8:  mwrite(ins[20:16], a + sx);
      6'd10: mwrite(ins[20:16], ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0);
      6'd13: mwrite(ins[20:16], a | {16'd0, ins[15:0]});
      6'd15: mwrite(ins[20:16], {ins[15:0], 16'd0});
      6'd4:  if (a == b) nxt = nxt + (sx << 2);
      6'd5:  if (a != b) nxt = nxt + (sx << 2);
      6'd2:  nxt = {nxt[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    mpc = nxt;
  endtask

  task automatic prepare_and_step();
    dbg_raddr = sweep;
    exp_dbg   = mreg[sweep];
    sweep     = sweep + 5'd1;
    model_step();
  endtask

  task automatic load_and_reset();
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      imem_we    = 1'b1;
      imem_waddr = AW'(i);
      imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    @(negedge clk);
    chk("R1 pc in reset", pc_out, 32'd0);
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mpc   = '0;
    sweep = '0;
    rst   = 1'b0;
    prepare_and_step();
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(tag_of(prog[0]) == "" ? "R13" : "R13 pc", pc_out, mpc);
      chk("R12 debug read", dbg_rdata, exp_dbg);
      prepare_and_step();
    end
  endtask

  task automatic read_reg(int idx, string tag, logic [31:0] exp);
    @(negedge clk);
    dbg_raddr = 5'(idx);
    @(negedge clk);
    chk(tag, dbg_rdata, exp);
  endtask

  // per-cycle PC check tagged with the class of the instruction just run
  task automatic run_tagged(int cycles);
    logic [31:0] last;
    for (int c = 0; c < cycles; c++) begin
      last = prog[mpc[AW+1:2]];
      @(negedge clk);
      chk(tag_of(last), pc_out, mpc);
      chk("R12 debug read", dbg_rdata, exp_dbg);
      prepare_and_step();
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // first program leaves register 20 non-zero before a second reset
    for (int i = 0; i < DEPTH; i++) prog[i] = '0;
    prog[0] = enc_i(8, 0, 20, 77);
    prog[1] = enc_j(1);
    load_and_reset();
    run(8);

    for (int i = 0; i < DEPTH; i++) prog[i] = '0;
    prog[0]  = enc_i(8, 0, 1, 5);
    prog[1]  = enc_i(8, 0, 2, -3);
    prog[2]  = enc_r(32, 1, 2, 3);
    prog[3]  = enc_r(34, 2, 1, 4);
    prog[4]  = enc_r(42, 2, 1, 5);
    prog[5]  = enc_r(42, 1, 2, 6);
    prog[6]  = enc_i(10, 2, 7, -2);
    prog[7]  = enc_i(10, 1, 8, 5);
    prog[8]  = enc_i(15, 0, 9, 16'hABAB);
    prog[9]  = enc_i(13, 9, 9, 16'hCDCD);
    prog[10] = enc_i(13, 0, 10, 16'h8000);
    prog[11] = enc_i(8, 1, 0, 7);
    prog[12] = enc_r(32, 0, 1, 11);
    prog[13] = {6'h3F, 5'd1, 5'd12, 16'h1234};
    prog[14] = enc_r(1, 1, 1, 12);
    prog[15] = enc_i(8, 13, 13, 1);
    prog[16] = enc_i(8, 1, 1, -1);
    prog[17] = enc_r(32, 14, 13, 14);
    prog[18] = enc_i(5, 1, 0, -4);
    prog[19] = enc_i(4, 1, 0, 1);
    prog[20] = enc_i(8, 0, 15, 99);
    prog[21] = enc_i(4, 1, 13, 1);
    prog[22] = enc_i(8, 0, 16, 1);
    prog[23] = enc_j(25);
    prog[24] = enc_i(8, 0, 17, 1);
    prog[25] = enc_j(25);
    load_and_reset();
    run_tagged(60);

    read_reg(20, "R1 cleared by reset", 32'd0);
    read_reg(3,  "R2 add", 32'd2);
    read_reg(4,  "R2 sub", 32'hFFFF_FFF8);
    read_reg(5,  "R3 slt true", 32'd1);
    read_reg(6,  "R3 slt false", 32'd0);
    read_reg(7,  "R4 slti true", 32'd1);
    read_reg(8,  "R4 slti equal", 32'd0);
    read_reg(2,  "R4 addi negative", 32'hFFFF_FFFD);
    read_reg(9,  "R6 upper then R5 or", 32'hABAB_CDCD);
    read_reg(10, "R5 zero extend", 32'h0000_8000);
    read_reg(0,  "R10 reg0 stays zero", 32'd0);
    read_reg(11, "R10 reg0 reads zero", 32'd5);
    read_reg(12, "R11 no write", 32'd0);
    read_reg(14, "R8 loop sum", 32'd15);
    read_reg(13, "R8 loop count", 32'd5);
    read_reg(15, "R7 taken skips", 32'd0);
    read_reg(16, "R7 not taken falls through", 32'd1);
    read_reg(17, "R9 jump skips", 32'd0);
    chk("R9 halted pc", pc_out, 32'd100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule